// File: doc/BRIEF.md
# Video Sync Code Inserter

This block sits at the end of a camera output path, between the stage that packs pixels into bytes and the output pins. A timing generator marks each byte with a horizontal window flag, a blanking-line flag, and per-line first-line and last-line flags. From these the block splices four-byte synchronization words into the byte stream. A receiver can then find lines and frames from the data alone, without separate sync wires.

Two code dialects are selectable. The marker dialect places words only on active lines. It uses distinct bytes for line start and line end, and special bytes for the start of the first active line and the end of the last one. The status dialect places a start word and an end word on every line, blanking lines included. Its final byte carries a V bit (blanking line) and an H bit (end of active pixels).

When insertion is on, the stream is delayed five cycles, so that a start word can occupy the four slots ahead of the first pixel byte. When insertion is off, bytes pass straight through in the same cycle.

Top module: `sync_code_inserter`

## Requirements
- R1: Every inserted word is four bytes on four consecutive cycles: 0xFF, 0x00, 0x00, then a code byte; `out_code` is 1 on exactly those cycles.
- R2: With `ins_en`=1, every input byte that is not overwritten by a word appears on `out_byte` unchanged, exactly 5 cycles after it was presented.
- R3: A start word fills the 4 output cycles just before the first window byte of a line. An end word fills the 4 output cycles just after the last window byte.
- R4: With `code_sel`=0 (marker dialect), the code byte is 0x00 for a line start and 0x01 for a line end.
- R5: With `code_sel`=0, on a line with `in_first`=1 the start code byte is 0x02. On a line with `in_last`=1 the end code byte is 0x03.
- R6: With `code_sel`=0, no word is inserted on a line with `in_vblank`=1; those output slots carry the delayed input bytes.
- R7: With `code_sel`=1 (status dialect), words are inserted on every line. The code byte is bit7=1, bit5=V (`in_vblank`), bit4=H (0 start, 1 end), bits 3:0=0, giving 0x80/0x90 on active lines and 0xA0/0xB0 on blanking lines. The first and last flags are ignored.
- R8: With `ins_en`=0, `out_byte` equals `in_byte` in the same cycle and `out_code` is 0.
- R9: After a synchronous reset with `ins_en`=1, `out_byte` is 0x00 and `out_code` is 0 until the first presented byte emerges 5 cycles later.
- R10: When exactly 8 non-window bytes separate two windows, the end word of one line and the start word of the next follow each other back to back, both intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one byte per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ins_en | input | 1 | 1 = insert words, 0 = zero-latency pass-through |
| code_sel | input | 1 | 0 = marker dialect, 1 = status dialect |
| in_byte | input | 8 | Incoming byte stream |
| in_hwin | input | 1 | Byte lies in the horizontal pixel window |
| in_vblank | input | 1 | Current line is a vertical blanking line |
| in_first | input | 1 | Current line is the first active line of the frame |
| in_last | input | 1 | Current line is the last active line of the frame |
| out_byte | output | 8 | Byte stream with words merged in |
| out_code | output | 1 | Current output byte belongs to an inserted word |

## Verification
The end word of one line and the arming of the next line's start word can land on the same clock edge. This happens when the sequencer is emitting the last byte of an end word while the next window's first byte arrives at the input. The bench provokes it by shrinking the line so that only 8 non-window bytes separate the windows, in both dialects. It then checks, cycle by cycle against an arithmetically built expectation, that the end word's code byte is followed directly by a complete 0xFF 0x00 0x00 preamble and the correct start byte.

// File: rtl/sci_pkg.sv
package sci_pkg;

    localparam int BYTE_W   = 8;
    localparam int CODE_LEN = 4;
    localparam int LAT      = CODE_LEN + 1;
    localparam int CNT_W    = $clog2(CODE_LEN);

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              hwin;
        logic              vblank;
        logic              last;
    } beat_t;

    typedef enum logic {
        CK_START = 1'b0,
        CK_END   = 1'b1
    } code_kind_e;

    typedef enum logic {
        DIALECT_MARK   = 1'b0,
        DIALECT_STATUS = 1'b1
    } dialect_e;

    // Final byte of a word for the chosen dialect.
    function automatic logic [BYTE_W-1:0] code_word(
        input dialect_e   d,
        input code_kind_e k,
        input logic       blank,
        input logic       frame_edge
    );
        logic [BYTE_W-1:0] w;
        if (d == DIALECT_MARK) begin
            w = {{(BYTE_W-2){1'b0}}, frame_edge, k == CK_END};
        end else begin
            w = {1'b1, 1'b0, blank, k == CK_END, {(BYTE_W-4){1'b0}}};
        end
        return w;
    endfunction

    // Leading bytes of every word: all ones, then zeros.
    function automatic logic [BYTE_W-1:0] preamble(input logic [CNT_W-1:0] idx);
        return (idx == '0) ? {BYTE_W{1'b1}} : {BYTE_W{1'b0}};
    endfunction

endpackage

// File: rtl/sci_delay.sv
module sci_delay
    import sci_pkg::*;
#(
    parameter int DEPTH = LAT
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t din,
    output logic  head_hwin,
    output logic  pre_tail_hwin,
    output beat_t tail
);
    beat_t stage [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[k] <= '0;
                else     stage[k] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[k] <= '0;
                else     stage[k] <= stage[k-1];
            end
        end
    end

    assign head_hwin     = stage[0].hwin;
    assign pre_tail_hwin = stage[DEPTH-2].hwin;
    assign tail          = stage[DEPTH-1];
endmodule

// File: rtl/sci_seq.sv
module sci_seq
    import sci_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_start,
    input  logic              arm_end,
    input  logic [BYTE_W-1:0] start_word,
    input  logic [BYTE_W-1:0] end_word,
    output logic              busy,
    output logic [BYTE_W-1:0] word_out
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_LEN - 1);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] code_q;
    logic              arm;

    assign arm = arm_start | arm_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            code_q <= '0;
        end else if (arm) begin
            busy   <= 1'b1;
            cnt    <= '0;
            code_q <= arm_end ? end_word : start_word;
        end else if (busy) begin
            if (cnt == LAST) busy <= 1'b0;
            else             cnt  <= cnt + 1'b1;
        end
    end

    assign word_out = (cnt == LAST) ? code_q : preamble(cnt);

    // R1: a word walks its slots one per cycle without gaps
    assert_slot_step_R1: assert property (@(posedge clk) disable iff (rst)
        busy && cnt != LAST && !arm |=> busy && cnt == $past(cnt) + 1'b1);

    // R1: a word only ends after its final slot
    assert_full_length_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(cnt) == LAST);

    // R10: a new word is only armed when the previous one is over or on its last byte
    assert_arm_idle_R10: assert property (@(posedge clk) disable iff (rst)
        arm |-> (!busy || cnt == LAST) && !(arm_start && arm_end));
endmodule

// File: rtl/sync_code_inserter.sv
module sync_code_inserter
    import sci_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_en,
    input  logic              code_sel,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_hwin,
    input  logic              in_vblank,
    input  logic              in_first,
    input  logic              in_last,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_code
);
    beat_t             in_beat;
    beat_t             tail;
    logic              head_hwin;
    logic              pre_tail_hwin;
    logic              start_go;
    logic              end_go;
    logic              busy;
    logic [BYTE_W-1:0] start_word;
    logic [BYTE_W-1:0] end_word;
    logic [BYTE_W-1:0] seq_word;
    dialect_e          dialect;

    assign dialect = dialect_e'(code_sel);
    assign in_beat = '{data: in_byte, hwin: in_hwin, vblank: in_vblank, last: in_last};

    sci_delay #(.DEPTH(LAT)) u_delay (
        .clk           (clk),
        .rst           (rst),
        .din           (in_beat),
        .head_hwin     (head_hwin),
        .pre_tail_hwin (pre_tail_hwin),
        .tail          (tail)
    );

    // Window opens at the input: word fills the four slots before pixel 1 leaves.
    assign start_go = ins_en && in_hwin && !head_hwin
                      && (dialect == DIALECT_STATUS || !in_vblank);
    // Window closes at the tail: last pixel is leaving now.
    assign end_go   = ins_en && tail.hwin && !pre_tail_hwin
                      && (dialect == DIALECT_STATUS || !tail.vblank);

    assign start_word = code_word(dialect, CK_START, in_vblank, in_first);
    assign end_word   = code_word(dialect, CK_END, tail.vblank, tail.last);

    sci_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .arm_start  (start_go),
        .arm_end    (end_go),
        .start_word (start_word),
        .end_word   (end_word),
        .busy       (busy),
        .word_out   (seq_word)
    );

    always_comb begin
        if (!ins_en)   out_byte = in_byte;
        else if (busy) out_byte = seq_word;
        else           out_byte = tail.data;
    end
    assign out_code = ins_en && busy;

    // R1: every word opens with the all-ones byte
    assert_word_lead_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(out_code) && ins_en |-> out_byte == 8'hFF);

    // R7: status dialect code bytes carry bit7 set and a clear low nibble
    assert_status_form_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(out_code) && ins_en && code_sel && $past(code_sel)
        |-> $past(out_byte[7]) && $past(out_byte[3:0]) == 4'h0);

    // R4: marker dialect code bytes stay within the four defined markers
    assert_mark_range_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(out_code) && ins_en && !code_sel && !$past(code_sel)
        |-> $past(out_byte) <= 8'h03);

    // R9: nothing is inserted in the first cycle after reset
    assert_reset_quiet_R9: assert property (@(posedge clk)
        $past(rst) && !rst |-> !out_code);
endmodule

// File: tb/test_sync_code_inserter.sv
module test_sync_code_inserter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ins_en = 1'b0;
    logic       code_sel = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_hwin = 1'b0;
    logic       in_vblank = 1'b1;
    logic       in_first = 1'b0;
    logic       in_last = 1'b0;
    logic [7:0] out_byte;
    logic       out_code;

    always #2.5 clk = ~clk;

    sync_code_inserter i_sync_code_inserter (
        .clk(clk), .rst(rst), .ins_en(ins_en), .code_sel(code_sel),
        .in_byte(in_byte), .in_hwin(in_hwin), .in_vblank(in_vblank),
        .in_first(in_first), .in_last(in_last),
        .out_byte(out_byte), .out_code(out_code)
    );

    localparam int MAXN  = 256;
    localparam int LINES = 6;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] s_byte [MAXN];
    logic       s_hw   [MAXN];
    logic       s_vb   [MAXN];
    logic       s_fi   [MAXN];
    logic       s_la   [MAXN];
    logic [7:0] e_byte [MAXN];
    logic       e_code [MAXN];
    string      e_tag  [MAXN];

    task automatic check_byte(input string tg, input logic [7:0] act, input logic [7:0] exp, input int t);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d out_byte actual=%02h expected=%02h", tg, t, act, exp);
        end
    endtask

    task automatic check_bit(input string tg, input logic act, input logic exp, input int t);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d out_code actual=%0b expected=%0b", tg, t, act, exp);
        end
    endtask

    task automatic put_word(input int at, input logic [7:0] cb, input string tg_last, input bit r10);
        for (int i = 0; i < 4; i++) begin
            e_code[at+i] = 1'b1;
            e_byte[at+i] = (i == 0) ? 8'hFF : (i == 3) ? cb : 8'h00;
            e_tag[at+i]  = r10 ? "R10" : (i == 3) ? tg_last : "R1";
        end
    endtask

    task automatic run_scenario(input bit sel, input bit en, input int len,
                                input int ws, input int wl, input bit r10, input int sc);
        int n;
        n = LINES * len + 12;
        // build stimulus
        for (int t = 0; t < n; t++) begin
            int line;
            int col;
            bit inf;
            line = t / len;
            col  = t % len;
            inf  = (t < LINES * len);
            s_hw[t]   = inf && col >= ws && col < ws + wl;
            s_vb[t]   = !inf || line == 0 || line == LINES - 1;
            s_fi[t]   = inf && line == 1;
            s_la[t]   = inf && line == LINES - 2;
            s_byte[t] = s_hw[t] ? 8'((line * 40 + col * 7 + 3 + sc * 11) & 255)
                                : 8'(8'h10 + (col & 15));
        end
        // expected stream: R2 delay, R8 bypass, R9 reset value
        for (int t = 0; t < n; t++) begin
            e_code[t] = 1'b0;
            if (!en) begin
                e_byte[t] = s_byte[t];
                e_tag[t]  = "R8";
            end else if (t < 5) begin
                e_byte[t] = 8'h00;
                e_tag[t]  = "R9";
            end else begin
                e_byte[t] = s_byte[t-5];
                e_tag[t]  = "R2";
            end
        end
        // R3 word positions: start at s+1..s+4, end at e+6..e+9
        if (en) begin
            for (int l = 0; l < LINES; l++) begin
                int s;
                int e;
                bit blank;
                s = l * len + ws;
                e = s + wl - 1;
                blank = (l == 0 || l == LINES - 1);
                if (sel) begin
                    put_word(s + 1, blank ? 8'hA0 : 8'h80, "R7", r10);
                    put_word(e + 6, blank ? 8'hB0 : 8'h90, "R7", r10);
                end else if (!blank) begin
                    put_word(s + 1, (l == 1) ? 8'h02 : 8'h00, (l == 1) ? "R5" : "R4", r10);
                    put_word(e + 6, (l == LINES - 2) ? 8'h03 : 8'h01,
                             (l == LINES - 2) ? "R5" : "R4", r10);
                end else begin
                    // R6: slots stay as delayed input on blanking lines
                    for (int i = 1; i <= 4; i++) e_tag[s+i] = "R6";
                    for (int i = 6; i <= 9; i++) e_tag[e+i] = "R6";
                end
            end
        end
        // reset, then drive one byte per cycle
        ins_en   = en;
        code_sel = sel;
        rst      = 1'b1;
        in_hwin  = 1'b0;
        in_byte  = 8'h00;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        for (int t = 0; t < n; t++) begin
            in_byte   = s_byte[t];
            in_hwin   = s_hw[t];
            in_vblank = s_vb[t];
            in_first  = s_fi[t];
            in_last   = s_la[t];
            #1.5;
            check_byte(e_tag[t], out_byte, e_byte[t], t);
            check_bit((e_tag[t] == "R2" || e_tag[t] == "R6") ? "R3" : e_tag[t],
                      out_code, e_code[t], t);
            @(posedge clk);
            #1;
        end
    endtask

    initial begin
        // marker dialect, wide gap
        run_scenario(1'b0, 1'b1, 24, 8, 8, 1'b0, 0);
        // status dialect, wide gap
        run_scenario(1'b1, 1'b1, 24, 8, 8, 1'b0, 1);
        // R10: exactly 8 non-window bytes between windows, both dialects
        run_scenario(1'b0, 1'b1, 16, 8, 8, 1'b1, 2);
        run_scenario(1'b1, 1'b1, 16, 8, 8, 1'b1, 3);
        // single-byte windows
        run_scenario(1'b0, 1'b1, 20, 6, 1, 1'b0, 4);
        run_scenario(1'b1, 1'b1, 20, 6, 1, 1'b0, 5);
        // R8: insertion off, both selects
        run_scenario(1'b0, 1'b0, 24, 8, 8, 1'b0, 6);
        run_scenario(1'b1, 1'b0, 24, 8, 8, 1'b0, 7);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule